// File: doc/BRIEF.md
# Re-Reference Counter Replacement Controller

This block holds the replacement state of one set-associative cache. Every way of every set owns a small re-reference counter. A counter at its top value marks a line the cache expects not to need soon, so that line is the first candidate for eviction. Hits pull a way's counter down to zero. Fills start a new line one step below the top, so a line that is used once and never again leaves quickly. Victim queries return the way to evict for a chosen set.

The surrounding cache controller sends three kinds of event, each tagged with a set index. Hit and fill events also carry a way. A victim query is accepted while the block is idle. The block then scans the set. If no way sits at the top value, it ages every counter of that set by one per cycle until one does. It then pulses a done strobe together with the chosen way.

A runtime mode input shrinks the effective counter range to a single bit. In that mode the block acts as a not-recently-used policy:
- hits and fills clear the bit;
- a set whose bits are all clear has them all set again when a victim is needed.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After reset every counter holds its all-ones value. A first query on any set returns way 0 with `vq_done_o` high one cycle after the query is sampled, and `vq_done_o` is low while reset is applied.
- R2: A hit sets the addressed way's counter to zero.
- R3: A fill sets the addressed way's counter to one below the effective maximum, which is 6 with the 3-bit default and 0 in single-bit mode.
- R4: The victim is the lowest-numbered way of the queried set whose counter is at or above the effective maximum (7 by default, 1 in single-bit mode).
- R5: If no way qualifies, all counters of the queried set rise by one in each scan cycle until one qualifies. Done appears k+1 cycles after the query sample edge, where k is the number of aging steps.
- R6: `vq_done_o` is a single-cycle pulse, and `vq_way_o` is valid in that cycle.
- R7: A query that arrives while a scan is in progress is ignored. It neither changes the set being scanned nor produces a second done.
- R8: With `nru_mode_i` high, hits and fills clear a way's state. A query on a set with every way cleared marks all of its ways evictable and returns way 0 after one aging step.
- R9: A hit and a fill in the same cycle are both applied. If they address the same set and way, the fill value is what remains.
- R10: Events and queries on one set leave the counters of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| nru_mode_i | input | 1 | 1 selects single-bit not-recently-used behaviour |
| hit_vld_i | input | 1 | Hit event valid |
| hit_set_i | input | $clog2(SETS) | Set index of the hit |
| hit_way_i | input | $clog2(WAYS) | Way of the hit |
| fill_vld_i | input | 1 | Fill event valid |
| fill_set_i | input | $clog2(SETS) | Set index of the fill |
| fill_way_i | input | $clog2(WAYS) | Way being filled |
| vq_vld_i | input | 1 | Victim query request |
| vq_set_i | input | $clog2(SETS) | Set to pick a victim in |
| vq_done_o | output | 1 | One-cycle strobe: victim found |
| vq_way_o | output | $clog2(WAYS) | Victim way, valid with the strobe |

## Verification
The assertions take two things for granted:
- `nru_mode_i` changes only while reset is applied;
- set and way indices stay within the configured ranges.

Under those conditions, aging never starts on a set that already holds an evictable way, so a counter cannot wrap. The stimulus selects the mode only inside reset and draws every index from legal ranges. It also sends overlapping hit, fill and query traffic, including queries issued in the middle of a scan, so the ignore rule and the same-cycle ordering are exercised against the reference model.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_BUSY = 1'b1
  } scan_st_e;

endpackage

// File: rtl/rrip_ctr_bank.sv
module rrip_ctr_bank #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int CW   = 3,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        eff_max,
  input  logic                 hit_vld,
  input  logic [SW-1:0]        hit_set,
  input  logic [WW-1:0]        hit_way,
  input  logic                 fill_vld,
  input  logic [SW-1:0]        fill_set,
  input  logic [WW-1:0]        fill_way,
  input  logic                 age_vld,
  input  logic [SW-1:0]        age_set,
  input  logic [SW-1:0]        rd_set,
  output logic [WAYS*CW-1:0]   rd_cnt
);

  logic [CW-1:0] cnt_q [SETS][WAYS];
  logic [CW-1:0] cnt_d [SETS][WAYS];
  logic [SETS-1:0] set_we;
  logic [CW-1:0] fill_val;

  assign fill_val = eff_max - CW'(1);

  // Priority per way: fill over hit over aging.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      set_we[s] = (hit_vld  && (hit_set  == SW'(s))) ||
                  (fill_vld && (fill_set == SW'(s))) ||
                  (age_vld  && (age_set  == SW'(s)));
      for (int w = 0; w < WAYS; w++) begin
        cnt_d[s][w] = cnt_q[s][w];
        if (age_vld && (age_set == SW'(s))) begin
          cnt_d[s][w] = cnt_q[s][w] + CW'(1);
        end
        if (hit_vld && (hit_set == SW'(s)) && (hit_way == WW'(w))) begin
          cnt_d[s][w] = '0;
        end
        if (fill_vld && (fill_set == SW'(s)) && (fill_way == WW'(w))) begin
          cnt_d[s][w] = fill_val;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          cnt_q[s][w] <= '1;
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (set_we[s]) begin
          for (int w = 0; w < WAYS; w++) begin
            cnt_q[s][w] <= cnt_d[s][w];
          end
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_cnt[w*CW +: CW] = cnt_q[rd_set][w];
    end
  end

  // Checks next to the storage they guard
  logic age_any;
  always_comb begin
    age_any = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (cnt_q[age_set][w] >= eff_max) age_any = 1'b1;
    end
  end

  a_r5_age_only_below_max : assert property (@(posedge clk) disable iff (!rst_n)
    age_vld |-> !age_any);

  a_r2_hit_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !(fill_vld && (fill_set == hit_set) && (fill_way == hit_way)))
    |=> (cnt_q[$past(hit_set)][$past(hit_way)] == '0));

  a_r3_fill_value : assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |=> (cnt_q[$past(fill_set)][$past(fill_way)] == CW'($past(eff_max) - CW'(1))));

endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
  parameter int WAYS = 4,
  parameter int CW   = 3,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic [WAYS*CW-1:0] cnt,
  input  logic [CW-1:0]      eff_max,
  output logic               found,
  output logic [WW-1:0]      way
);

  // Scan from the top down so the lowest qualifying way wins.
  always_comb begin
    found = 1'b0;
    way   = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (cnt[w*CW +: CW] >= eff_max) begin
        found = 1'b1;
        way   = WW'(w);
      end
    end
  end

endmodule

// File: rtl/rrip_scan_fsm.sv
module rrip_scan_fsm
  import rrip_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [SW-1:0] req_set,
  input  logic          found,
  input  logic [WW-1:0] pick_way,
  output logic [SW-1:0] scan_set,
  output logic          age_vld,
  output logic          done,
  output logic [WW-1:0] way
);

  scan_st_e      st_q, st_d;
  logic [SW-1:0] set_q, set_d;
  logic          set_en;
  logic          done_q, done_d;
  logic [WW-1:0] way_q;

  always_comb begin
    st_d    = st_q;
    set_d   = set_q;
    set_en  = 1'b0;
    done_d  = 1'b0;
    age_vld = 1'b0;
    case (st_q)
      SCAN_IDLE: begin
        if (req_vld) begin
          set_d  = req_set;
          set_en = 1'b1;
          st_d   = SCAN_BUSY;
        end
      end
      SCAN_BUSY: begin
        if (found) begin
          done_d = 1'b1;
          st_d   = SCAN_IDLE;
        end else begin
          age_vld = 1'b1;
        end
      end
      default: st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      set_q  <= '0;
      done_q <= 1'b0;
      way_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (set_en) set_q <= set_d;
      if (done_d) way_q <= pick_way;
    end
  end

  assign scan_set = set_q;
  assign done     = done_q;
  assign way      = way_q;

  a_r6_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r4_done_follows_find : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(found) && ($past(st_q) == SCAN_BUSY)));

  a_r7_set_held_while_scanning : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SCAN_BUSY) && !found) |=> ((st_q == SCAN_BUSY) && $stable(set_q)));

endmodule

// File: rtl/rrip_repl_ctrl.sv
module rrip_repl_ctrl #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int CW   = 3,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nru_mode_i,
  input  logic          hit_vld_i,
  input  logic [SW-1:0] hit_set_i,
  input  logic [WW-1:0] hit_way_i,
  input  logic          fill_vld_i,
  input  logic [SW-1:0] fill_set_i,
  input  logic [WW-1:0] fill_way_i,
  input  logic          vq_vld_i,
  input  logic [SW-1:0] vq_set_i,
  output logic          vq_done_o,
  output logic [WW-1:0] vq_way_o
);

  logic [CW-1:0]      eff_max;
  logic [SW-1:0]      scan_set;
  logic               age_vld;
  logic [WAYS*CW-1:0] rd_cnt;
  logic               found;
  logic [WW-1:0]      pick_way;

  assign eff_max = nru_mode_i ? CW'(1) : {CW{1'b1}};

  rrip_ctr_bank #(.WAYS(WAYS), .SETS(SETS), .CW(CW)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_max  (eff_max),
    .hit_vld  (hit_vld_i),
    .hit_set  (hit_set_i),
    .hit_way  (hit_way_i),
    .fill_vld (fill_vld_i),
    .fill_set (fill_set_i),
    .fill_way (fill_way_i),
    .age_vld  (age_vld),
    .age_set  (scan_set),
    .rd_set   (scan_set),
    .rd_cnt   (rd_cnt)
  );

  rrip_victim_pick #(.WAYS(WAYS), .CW(CW)) pick_i (
    .cnt     (rd_cnt),
    .eff_max (eff_max),
    .found   (found),
    .way     (pick_way)
  );

  rrip_scan_fsm #(.WAYS(WAYS), .SETS(SETS)) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (vq_vld_i),
    .req_set  (vq_set_i),
    .found    (found),
    .pick_way (pick_way),
    .scan_set (scan_set),
    .age_vld  (age_vld),
    .done     (vq_done_o),
    .way      (vq_way_o)
  );

endmodule

// File: tb/rrip_repl_ctrl_tb_top.sv
module rrip_repl_ctrl_tb_top;

  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int CW   = 3;
  localparam int SW   = $clog2(SETS);
  localparam int WW   = $clog2(WAYS);

  logic          clk;
  logic          rst_n;
  logic          nru_mode;
  logic          hv, fv, qv;
  logic [SW-1:0] hs, fs, qs;
  logic [WW-1:0] hw, fw;
  logic          done;
  logic [WW-1:0] vway;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";

  rrip_repl_ctrl #(.WAYS(WAYS), .SETS(SETS), .CW(CW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nru_mode_i (nru_mode),
    .hit_vld_i  (hv),
    .hit_set_i  (hs),
    .hit_way_i  (hw),
    .fill_vld_i (fv),
    .fill_set_i (fs),
    .fill_way_i (fw),
    .vq_vld_i   (qv),
    .vq_set_i   (qs),
    .vq_done_o  (done),
    .vq_way_o   (vway)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference model
  int m [SETS][WAYS];
  bit m_busy;
  int m_set;
  bit e_done;
  int e_way;

  function automatic int top_val();
    return nru_mode ? 1 : (1 << CW) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) m[s][w] = (1 << CW) - 1;
      m_busy = 0;
      m_set  = 0;
      e_done = 0;
      e_way  = 0;
    end else begin
      bit age;
      int aset;
      age  = 0;
      aset = m_set;
      e_done = 0;
      if (!m_busy) begin
        if (qv) begin
          m_busy = 1;
          m_set  = int'(qs);
        end
      end else begin
        int pick;
        pick = -1;
        for (int w = 0; w < WAYS; w++)
          if (pick < 0 && m[m_set][w] >= top_val()) pick = w;
        if (pick >= 0) begin
          e_done = 1;
          e_way  = pick;
          m_busy = 0;
        end else begin
          age = 1;
        end
      end
      if (age) for (int w = 0; w < WAYS; w++) m[aset][w] = m[aset][w] + 1;
      if (hv) m[hs][hw] = 0;
      if (fv) m[fs][fw] = top_val() - 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Every cycle: compare the outputs with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(phase, "done strobe vs model", int'(done), int'(e_done));
      if (e_done) chk(phase, "victim way vs model", int'(vway), e_way);
    end
  end

  task automatic drive(bit h, int hset, int hway, bit f, int fset, int fway, bit q, int qset);
    hv = h; hs = SW'(hset); hw = WW'(hway);
    fv = f; fs = SW'(fset); fw = WW'(fway);
    qv = q; qs = SW'(qset);
    @(negedge clk);
    hv = 0; fv = 0; qv = 0;
  endtask

  task automatic do_hit(int s, int w);  drive(1, s, w, 0, 0, 0, 0, 0); endtask
  task automatic do_fill(int s, int w); drive(0, 0, 0, 1, s, w, 0, 0); endtask

  task automatic query(int s, int intr, output int way, output int n);
    drive(0, 0, 0, 0, 0, 0, 1, s);
    n = 0;
    do begin
      if (intr >= 0 && n == 2) begin
        qv = 1; qs = SW'(intr);
      end
      @(negedge clk);
      qv = 0;
      n++;
    end while (!done && n < 40);
    way = int'(vway);
  endtask

  task automatic do_reset(bit mode);
    rst_n = 0;
    nru_mode = mode;
    repeat (3) @(negedge clk);
    chk("R1", "done low in reset", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic random_phase(int cycles);
    for (int i = 0; i < cycles; i++) begin
      drive($urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, WAYS-1),
            $urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, WAYS-1),
            $urandom_range(0, 3) == 0, $urandom_range(0, 3));
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int way, n;
    hv = 0; fv = 0; qv = 0; hs = '0; fs = '0; qs = '0; hw = '0; fw = '0;
    rst_n = 0; nru_mode = 0;
    @(negedge clk);
    do_reset(0);

    // R1: cold sets evict way 0 with no aging
    phase = "R1";
    chk("R1", "done low after reset", int'(done), 0);
    query(5, -1, way, n);
    chk("R1", "cold victim way", way, 0);
    chk("R1", "cold latency", n, 1);

    // R3 / R4: fill lowers a way to 6, next way is chosen
    phase = "R3";
    do_fill(5, 0);
    query(5, -1, way, n);
    chk("R4", "lowest way at max", way, 1);
    for (int w = 1; w < WAYS; w++) do_fill(5, w);
    phase = "R5";
    query(5, -1, way, n);
    chk("R5", "one aging step victim", way, 0);
    chk("R5", "one aging step latency", n, 2);
    @(negedge clk);
    chk("R6", "done is one cycle", int'(done), 0);

    // R2 / R5 / R7 on set 2
    phase = "R2";
    for (int w = 0; w < WAYS; w++) do_fill(2, w);
    do_hit(2, 0);
    query(2, -1, way, n);
    chk("R2", "hit way kept, next aged", way, 1);
    chk("R5", "aging latency", n, 2);
    for (int w = 1; w < WAYS; w++) do_hit(2, w);
    phase = "R7";
    query(2, 11, way, n);
    chk("R5", "six aging steps victim", way, 0);
    chk("R5", "six aging steps latency", n, 7);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7", "no done from ignored query", int'(done), 0);
    end

    // R9: same-cycle hit and fill on one way, fill wins
    phase = "R9";
    for (int w = 0; w < WAYS; w++) do_fill(7, w);
    for (int w = 0; w < 3; w++) do_hit(7, w);
    drive(1, 7, 3, 1, 7, 3, 0, 0);
    query(7, -1, way, n);
    chk("R9", "fill value survives", way, 3);
    chk("R9", "fill survives latency", n, 2);

    // R10: untouched set still cold
    phase = "R10";
    query(9, -1, way, n);
    chk("R10", "other set unchanged way", way, 0);
    chk("R10", "other set unchanged latency", n, 1);

    phase = "R9";
    random_phase(3000);

    // R8: single-bit mode
    do_reset(1);
    phase = "R8";
    query(1, -1, way, n);
    chk("R8", "cold way in single-bit mode", way, 0);
    do_fill(1, 0);
    do_hit(1, 1);
    query(1, -1, way, n);
    chk("R8", "cleared ways skipped", way, 2);
    do_fill(1, 2);
    do_fill(1, 3);
    query(1, -1, way, n);
    chk("R8", "all clear re-marked victim", way, 0);
    chk("R8", "all clear latency", n, 2);

    random_phase(3000);
    finish_run();
  end

endmodule